// File: doc/BRIEF.md
# Systolic Lower-Triangular Equation Solver

This block solves A·x = b by forward substitution on a linear systolic array of N cells. A is an N×N lower-triangular matrix of signed fixed-point values with a non-zero diagonal, and b is an N-vector. Cell 0 is the boundary cell and divides. Cells 1 to N−1 do a multiply-subtract. Each partial right-hand side b_i enters cell i and walks toward cell 0. On the way it meets the already-solved x values, which flow outward from cell 0 one cell per step. A coefficient scheduler picks, on every array step, the matrix entry that each cell needs. The entries reach the cells in a diagonal skew, so every cell sees its coefficient in the same step as the matching b and x.

The user places A and b on wide parallel inputs and pulses `start`. The inputs must stay stable until `done`. The block then streams x_0 to x_{N−1} out in index order, one strobe per value, and pulses `done` after the last one. The boundary divider is a multi-cycle restoring divider. While it works, it freezes the whole array through a global step enable. A zero diagonal entry does not stop the solve: it yields a zero result and a sticky error flag.

Top module: `tri_solver`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `start`, `busy`, `x_valid`, `done` and `div_by_zero` are all 0.
- R2: A `start` seen while idle begins a solve. `busy` is 1 during the solve and 0 again after `done`. A `start` seen while busy changes neither the results nor the latency.
- R3: Entry a_ij (row i, column j, 0-based) is read from `a_flat[(i*N+j)*W +: W]` and b_i from `b_flat[i*W +: W]`. Entries with j > i have no effect on any output.
- R4: All values are two's complement W bits with F fraction bits. x_i equals (b_i − Σ_{j<i} a_ij·x_j) / a_ii. Each product is shifted right arithmetically by F bits, the subtractions are applied for j = 0, 1, … in increasing order, and the quotient (remainder shifted left by F, divided by a_ii) is truncated toward zero.
- R5: Each solve gives exactly N `x_valid` strobes. The strobes carry x_0 to x_{N−1} in index order on `x_out`, and no two of them fall in consecutive cycles.
- R6: `done` is high for exactly one cycle, the cycle right after the strobe of x_{N−1}.
- R7: Every multiply-subtract saturates to the range [−2^(W−1), 2^(W−1)−1]. A quotient whose magnitude exceeds 2^(W−1)−1 is clamped to that magnitude with its sign kept.
- R8: If a_ii = 0, x_i is emitted as 0 and `div_by_zero` rises in the cycle of that strobe. The flag then stays at 1 until reset, across later solves.
- R9: A solve runs 2N−1 array steps. Each even step holds the array for the W+F-cycle divider. The cycle in which `start` is high and the cycle in which `done` is high are N·(W+F+2)+N+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve (taken only while idle) |
| a_flat | input | N*N*W | Matrix entries, row-major, held stable while busy |
| b_flat | input | N*W | Right-hand side, held stable while busy |
| busy | output | 1 | Solve in progress |
| x_valid | output | 1 | Strobe: `x_out` carries the next solution element |
| x_out | output | W | Solution element, signed fixed point |
| done | output | 1 | One-cycle pulse after the last element |
| div_by_zero | output | 1 | Sticky flag: a zero diagonal entry was met |

## Verification
Random systems with small integer coefficients and diagonals in {1, 2, 4, −1, −2} have exact fixed-point answers, and garbage above the diagonal exposes a scheduler that reads the wrong index: such a design gives wrong x values. A system built to push b_1 past full scale catches a multiply-subtract that wraps instead of clamping, which would output a large negative x_1. A zero diagonal must give a zero element and a flag that survives the next solve, and a design that cleared the flag on `start` or sent out an unguarded quotient would fail here. The start-to-done cycle count and a `start` pulse in the middle of a solve catch a wrong stall count or a restart that is not blocked.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_DIV  = 2'd2
  } tss_state_e;
endpackage

// File: rtl/tss_mac_cell.sv
// Inner systolic cell: b_out = sat(b - (a*x >>> F)) when a and x are present.
module tss_mac_cell #(
  parameter int W = 24,
  parameter int F = 8
) (
  input  logic signed [W-1:0] b_in,
  input  logic                b_vld,
  input  logic signed [W-1:0] a_in,
  input  logic                a_vld,
  input  logic signed [W-1:0] x_in,
  input  logic                x_vld,
  output logic signed [W-1:0] b_out,
  output logic                b_out_vld
);
  localparam int PW = 2 * W;
  localparam logic signed [PW:0] HI = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW:0] LO = {{(W+2){1'b1}}, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sc;
  logic signed [PW:0]   diff;
  logic signed [W-1:0]  sat_v;

  assign prod    = a_in * x_in;
  assign prod_sc = prod >>> F;
  assign diff    = {{(W+1){b_in[W-1]}}, b_in} - {prod_sc[PW-1], prod_sc};

  always_comb begin
    if (diff > HI)      sat_v = HI[W-1:0];
    else if (diff < LO) sat_v = LO[W-1:0];
    else                sat_v = diff[W-1:0];
  end

  assign b_out     = (a_vld && x_vld) ? sat_v : b_in;
  assign b_out_vld = b_vld;
endmodule

// File: rtl/tss_divider.sv
// Boundary divider: quot = (num << F) / den, restoring, one bit per cycle.
module tss_divider #(
  parameter int W = 24,
  parameter int F = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] quot,
  output logic                dz
);
  localparam int DW = W + F;
  localparam int CW = $clog2(DW);

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? W'(~v + 1'b1) : v;
  endfunction

  logic          busy_q, busy_n, done_q, done_n, neg_q, neg_n, dz_q, dz_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  rem_q, rem_n, dvs_q, dvs_n;
  logic [DW-1:0] quo_q, quo_n;
  logic [W:0]    rem_sh;
  logic [W-1:0]  qmag;

  assign rem_sh = {rem_q, quo_q[DW-1]};

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    neg_n  = neg_q;
    dz_n   = dz_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      rem_n  = '0;
      quo_n  = {mag(num), {F{1'b0}}};
      dvs_n  = mag(den);
      neg_n  = num[W-1] ^ den[W-1];
      dz_n   = (den == '0);
    end else if (busy_q) begin
      if (rem_sh >= {1'b0, dvs_q}) begin
        rem_n = W'(rem_sh - {1'b0, dvs_q});
        quo_n = {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_n = rem_sh[W-1:0];
        quo_n = {quo_q[DW-2:0], 1'b0};
      end
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(DW - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      neg_q  <= neg_n;
      dz_q   <= dz_n;
    end
  end

  // Clamp magnitude (R7), apply sign, force zero on zero divisor (R8).
  assign qmag = (|quo_q[DW-1:W-1]) ? {1'b0, {(W-1){1'b1}}} : quo_q[W-1:0];
  assign quot = dz_q ? '0 : (neg_q ? W'(~qmag + 1'b1) : qmag);
  assign busy = busy_q;
  assign done = done_q;
  assign dz   = dz_q;

  p_div_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/tss_feeder.sv
// Skew scheduler: at step t, lane k gets a[(t+k)/2][(t-k)/2] when t>=k,
// t+k even and the row is in range.
module tss_feeder #(
  parameter int N  = 4,
  parameter int W  = 24,
  parameter int SW = 3
) (
  input  logic [SW-1:0]    step,
  input  logic [N*N*W-1:0] a_flat,
  output logic [N*W-1:0]   coef,
  output logic [N-1:0]     coef_vld
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    int         sum_v, dif_v, row_v, col_v, sel_v;
    logic       hit;
    logic [W-1:0] c;
    always_comb begin
      sum_v = int'(step) + k;
      dif_v = int'(step) - k;
      row_v = sum_v / 2;
      col_v = dif_v / 2;
      hit   = (dif_v >= 0) && ((sum_v % 2) == 0) && (row_v < N);
      sel_v = hit ? (row_v * N + col_v) : 0;
      c     = a_flat[sel_v*W +: W];
    end
    assign coef[k*W +: W] = c;
    assign coef_vld[k]    = hit;
  end
endmodule

// File: rtl/tri_solver.sv
module tri_solver #(
  parameter int N = 4,
  parameter int W = 24,
  parameter int F = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N*N*W-1:0]    a_flat,
  input  logic [N*W-1:0]      b_flat,
  output logic                busy,
  output logic                x_valid,
  output logic signed [W-1:0] x_out,
  output logic                done,
  output logic                div_by_zero
);
  import tss_pkg::*;

  localparam int LAST = 2 * N - 2;
  localparam int SW   = $clog2(2 * N);

  tss_state_e state_q, state_n;
  logic [SW-1:0]       t_q, t_n;
  logic signed [W-1:0] br_q [N];
  logic signed [W-1:0] br_n [N];
  logic [N-1:0]        bv_q, bv_n;
  logic signed [W-1:0] xr_q [1:N-1];
  logic signed [W-1:0] xr_n [1:N-1];
  logic [N-1:1]        xv_q, xv_n;
  logic                xval_q, xval_n, lastx_q, lastx_n, done_q, dz_q, dz_n;
  logic signed [W-1:0] xout_q, xout_n;

  logic [N*W-1:0]      coef;
  logic [N-1:0]        coef_vld;
  logic signed [W-1:0] cout [1:N-1];
  logic [N-1:1]        cvld;
  logic                div_start, div_busy, div_done, div_dz, step_en, last_step;
  logic signed [W-1:0] div_q, div_den;

  tss_feeder #(.N(N), .W(W), .SW(SW)) u_feed (
    .step(t_q), .a_flat(a_flat), .coef(coef), .coef_vld(coef_vld));

  for (genvar k = 1; k < N; k++) begin : g_cell
    tss_mac_cell #(.W(W), .F(F)) u_cell (
      .b_in(br_q[k]), .b_vld(bv_q[k]),
      .a_in(coef[k*W +: W]), .a_vld(coef_vld[k]),
      .x_in(xr_q[k]), .x_vld(xv_q[k]),
      .b_out(cout[k]), .b_out_vld(cvld[k]));
  end

  assign div_den = coef_vld[0] ? coef[W-1:0] : '0;

  tss_divider #(.W(W), .F(F)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(br_q[0]), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_q), .dz(div_dz));

  // Global step enable: odd steps advance at once, even steps wait for the divider.
  assign div_start = (state_q == ST_STEP) && bv_q[0];
  assign step_en   = ((state_q == ST_STEP) && !bv_q[0]) ||
                     ((state_q == ST_DIV) && div_done);
  assign last_step = (t_q == SW'(LAST));

  always_comb begin
    state_n = state_q;
    t_n     = t_q;
    br_n    = br_q;
    bv_n    = bv_q;
    xr_n    = xr_q;
    xv_n    = xv_q;
    xval_n  = 1'b0;
    xout_n  = xout_q;
    lastx_n = 1'b0;
    dz_n    = dz_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_STEP;
          t_n     = '0;
          for (int k = 0; k < N; k++) br_n[k] = b_flat[k*W +: W];
          bv_n    = N'(1);
          xv_n    = '0;
        end
      end
      ST_STEP: if (div_start) state_n = ST_DIV;
      ST_DIV:  ;
      default: state_n = ST_IDLE;
    endcase
    if (step_en) begin
      for (int k = 0; k < N; k++) begin
        if (int'(t_q) + 1 == k) begin
          br_n[k] = b_flat[k*W +: W];
          bv_n[k] = 1'b1;
        end else if (k < N - 1) begin
          br_n[k] = cout[k+1];
          bv_n[k] = cvld[k+1];
        end else begin
          br_n[k] = '0;
          bv_n[k] = 1'b0;
        end
      end
      xr_n[1] = div_q;
      xv_n[1] = bv_q[0];
      for (int k = 2; k < N; k++) begin
        xr_n[k] = xr_q[k-1];
        xv_n[k] = xv_q[k-1];
      end
      if (bv_q[0]) begin
        xval_n  = 1'b1;
        xout_n  = div_q;
        lastx_n = last_step;
        dz_n    = dz_q | div_dz;
      end
      t_n     = t_q + 1'b1;
      state_n = last_step ? ST_IDLE : ST_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
      bv_q    <= '0;
      xv_q    <= '0;
      xval_q  <= 1'b0;
      xout_q  <= '0;
      lastx_q <= 1'b0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
      for (int k = 0; k < N; k++) br_q[k] <= '0;
      for (int k = 1; k < N; k++) xr_q[k] <= '0;
    end else begin
      state_q <= state_n;
      t_q     <= t_n;
      bv_q    <= bv_n;
      xv_q    <= xv_n;
      xval_q  <= xval_n;
      xout_q  <= xout_n;
      lastx_q <= lastx_n;
      done_q  <= lastx_q;
      dz_q    <= dz_n;
      br_q    <= br_n;
      xr_q    <= xr_n;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign x_valid     = xval_q;
  assign x_out       = xout_q;
  assign done        = done_q;
  assign div_by_zero = dz_q;

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !step_en);
  p_xv_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid |=> !x_valid);
  p_done_after_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(x_valid));
  p_dz_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |=> div_by_zero);
  p_dz_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_by_zero) |-> (x_valid && x_out == '0));
endmodule

// File: tb/tb_tri_solver.sv
module tb_tri_solver;
  localparam int N = 4;
  localparam int W = 24;
  localparam int F = 8;
  localparam int DW = W + F;
  localparam int LAT = N * (DW + 2) + N + 1;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 6;
  localparam int unsigned SEEDS [NCASE] = '{32'h0000_1234, 32'h00C0_FFEE, 32'h0BAD_5EED,
                                            32'h7777_0001, 32'h0031_4159, 32'h00AB_CDEF};

  logic clk, rst_n, start;
  logic [N*N*W-1:0] a_flat;
  logic [N*W-1:0] b_flat;
  logic busy, x_valid, done, div_by_zero;
  logic signed [W-1:0] x_out;

  logic signed [W-1:0] am [N][N];
  logic signed [W-1:0] bm [N];
  longint exp_x [N];
  longint got [N];
  int n_chk, n_fail;

  tri_solver #(.N(N), .W(W), .F(F)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_flat(a_flat), .b_flat(b_flat),
    .busy(busy), .x_valid(x_valid), .x_out(x_out), .done(done), .div_by_zero(div_by_zero));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int unsigned lcg(input int unsigned s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic longint clampw(input longint v, input bit sym);
    longint hi = (longint'(1) <<< (W - 1)) - 1;
    longint lo = sym ? -hi : -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic gen(input int unsigned seed);
    int unsigned s = seed;
    int v;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        s = lcg(s);
        if (j < i) begin
          v = int'((s >> 16) % 7) - 3;
          am[i][j] = W'(v * (1 << F));
        end else if (j == i) begin
          case ((s >> 16) % 5)
            0: v = 1; 1: v = 2; 2: v = 4; 3: v = -1; default: v = -2;
          endcase
          am[i][j] = W'(v * (1 << F));
        end else begin
          am[i][j] = W'(s);  // R3: garbage above the diagonal
        end
      end
      s = lcg(s);
      v = int'((s >> 16) % 41) - 20;
      bm[i] = W'(v * (1 << F));
    end
  endtask

  // Forward substitution per R4/R7/R8.
  task automatic model();
    longint r, d;
    for (int i = 0; i < N; i++) begin
      r = longint'(bm[i]);
      for (int j = 0; j < i; j++)
        r = clampw(r - ((longint'(am[i][j]) * exp_x[j]) >>> F), 1'b0);
      d = longint'(am[i][i]);
      exp_x[i] = (d == 0) ? 0 : clampw((r <<< F) / d, 1'b1);
    end
  endtask

  task automatic run_case(input bit mid_start);
    int cnt, nx, lastx_cnt, done_cnt;
    bit prev, seen_done;
    model();
    for (int i = 0; i < N; i++) begin
      b_flat[i*W +: W] = bm[i];
      for (int j = 0; j < N; j++) a_flat[(i*N+j)*W +: W] = am[i][j];
    end
    start = 1'b1;
    cnt = 0; nx = 0; lastx_cnt = -1; done_cnt = -1; prev = 1'b0; seen_done = 1'b0;
    while (!seen_done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      start = mid_start && (cnt == 20);
      if (cnt == 2) chk(busy == 1'b1, "R2 busy during solve", busy, 1);
      if (x_valid) begin
        chk(!prev, "R5 strobes not back to back", 1, 0);
        if (nx < N) got[nx] = longint'(x_out);
        nx++;
        lastx_cnt = cnt;
      end
      if (done) begin
        seen_done = 1'b1;
        done_cnt = cnt;
      end
      prev = x_valid;
    end
    chk(nx == N, "R5 strobe count", nx, N);
    for (int i = 0; i < N; i++)
      chk(got[i] == exp_x[i], $sformatf("R3 R4 x[%0d]", i), got[i], exp_x[i]);
    chk(done_cnt == lastx_cnt + 1, "R6 done after last x", done_cnt, lastx_cnt + 1);
    chk(done_cnt == LAT, mid_start ? "R2 R9 latency with extra start" : "R9 latency",
        done_cnt, LAT);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    chk(busy == 1'b0, "R2 idle after done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; a_flat = '0; b_flat = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !x_valid && !done && !div_by_zero, "R1 outputs low in reset",
        {busy, x_valid, done, div_by_zero}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !x_valid && !done && !div_by_zero, "R1 outputs low after release",
        {busy, x_valid, done, div_by_zero}, 0);

    // Table walk: random exactly representable systems.
    for (int c = 0; c < NCASE; c++) begin
      gen(SEEDS[c]);
      run_case(c == 2);
    end
    chk(div_by_zero == 1'b0, "R8 flag clear with non-zero diagonals", div_by_zero, 0);

    // R7: b_1 - a_10*x_0 overflows, must clamp to full scale.
    gen(32'h5A5A_0000);
    for (int i = 0; i < N; i++) for (int j = 0; j <= i; j++) am[i][j] = '0;
    for (int i = 0; i < N; i++) am[i][i] = W'(1 << F);
    bm[0] = W'(100 * (1 << F));
    am[1][0] = W'(-400 * (1 << F));
    bm[1] = '0;
    bm[2] = W'(5 * (1 << F));
    bm[3] = W'(-7 * (1 << F));
    run_case(1'b0);
    chk(got[1] == (longint'(1) <<< (W - 1)) - 1, "R7 saturated multiply-subtract",
        got[1], (longint'(1) <<< (W - 1)) - 1);

    // R8: zero diagonal entry.
    gen(32'h0000_BEEF);
    am[1][1] = '0;
    run_case(1'b0);
    chk(got[1] == 0, "R8 zero diagonal gives zero x", got[1], 0);
    chk(div_by_zero == 1'b1, "R8 flag set", div_by_zero, 1);
    gen(SEEDS[0]);
    run_case(1'b0);
    chk(div_by_zero == 1'b1, "R8 flag sticky across solves", div_by_zero, 1);

    // R1: reset clears the sticky flag.
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !x_valid && !done && !div_by_zero, "R1 reset clears state",
        {busy, x_valid, done, div_by_zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule